// File: doc/BRIEF.md
# Ping-Pong Dual-Port Sample Buffer

This block holds I/Q sample bytes in transit between a host processor bus and a data-converter interface. Its storage is a small bank of flip-flops split into two equal halves. One side fills or drains one half while the other side works on the opposite half. A direction input picks the flow. In transmit, the host writes and the converter side reads. In receive, the converter side writes and the host reads.

Each side has its own address counter. The converter counter steps on one edge of the converter clock. When its low bits wrap, meaning a half has just been completed, the block raises a one-cycle DMA request, and the host moves exactly one half's worth of words in response. The host half-select is always the inverse of the converter half-select, so both sides can never work on the same half at once. Each DMA request also clears the host word counter, which recovers from stray strobes.

The host strobe and the converter clock are both sampled into one system clock through synchronisers. Their edges act as enables. A two-state machine tracks the direction: `CV_RX` (receive) and `CV_TX` (transmit). The machine moves `CV_RX -> CV_TX` when the direction input goes high and `CV_TX -> CV_RX` when it goes low. Each of these transitions clears the converter address counter.

Top module: `pp_sample_buf`

## Requirements
- R1: After a synchronous reset, both address counters are zero and every stored word is zero, so both data outputs read 0 and no DMA request is pending. The host address is then half 1, word 0.
- R2: In transmit (`dir_tx`=1), each falling edge of `host_stb` stores `host_din` at host address {~converter MSB, host word count}. The host word count then advances by one.
- R3: In receive (`dir_tx`=0), each falling edge of `cnv_clk` stores `cnv_din` at the converter address. The converter address then advances by one.
- R4: The host half-select (address bit 3) is always the inverse of the converter address bit 3. Address bits 2:0 select the word within the half.
- R5: The converter address advances only on rising `cnv_clk` edges in transmit and only on falling edges in receive. All other activity leaves it unchanged.
- R6: `dma_req` is a single-cycle pulse. It is raised once each time the converter address steps to 8 or to 0, which is once per 8 converter steps.
- R7: Every DMA request clears the host word count to 0.
- R8: Any change of `dir_tx` clears the converter address to 0 and raises no DMA request. The host word count keeps its value.
- R9: Data outputs are read without a clock. `host_dout` shows the word at the host address, and `cnv_dout` shows the word at the converter address.
- R10: Strobes on the side that is not the writer store nothing and change only that side's counter. This covers host strobes in receive and `cnv_din` in transmit. The rising edge of the host strobe never moves the host count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| host_stb | input | 1 | Host strobe pulse; acts on its falling edge |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Word at the host address |
| cnv_clk | input | 1 | Converter sample clock |
| cnv_din | input | 8 | Converter write data |
| cnv_dout | output | 8 | Word at the converter address |
| dma_req | output | 1 | One-cycle request to move one half |

## Verification
The bench builds the block with its defaults: 8-bit words, 8-word halves and two synchroniser stages. With these values a complete sweep is short. It covers four full half-swaps in each direction, every address of both halves, and both wrap points of the converter counter, each checked word by word. Stray host strobes, ignored write data and direction flips taken mid-count are driven in between. Expected contents, addresses and the DMA pulse count come from an arithmetic model of the requirements.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
    typedef enum logic {
        CV_RX = 1'b0,
        CV_TX = 1'b1
    } cv_state_t;
endpackage

// File: rtl/pp_edge_sync.sv
module pp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
    assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/pp_cnv_addr.sv
module pp_cnv_addr
    import pp_buf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_tx,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic              dma_o,
    output cv_state_t         state_o
);
    localparam int LO_W = ADDR_W - 1;

    cv_state_t         state_q, state_d;
    logic              flip, adv;
    logic [ADDR_W-1:0] addr_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CV_RX;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_RX: if (dir_tx)  state_d = CV_TX;
            CV_TX: if (!dir_tx) state_d = CV_RX;
        endcase
    end

    // outputs: advance select and write strobe
    always_comb begin
        flip = (state_d != state_q);
        adv  = 1'b0;
        wr_o = 1'b0;
        unique case (state_q)
            CV_RX: begin
                adv  = fall_i;
                wr_o = fall_i & ~flip;
            end
            CV_TX: adv = rise_i;
        endcase
    end

    assign addr_nx = addr_o + 1'b1;
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst || flip) begin
            addr_o <= '0;
            dma_o  <= 1'b0;
        end else begin
            dma_o <= adv && (addr_nx[LO_W-1:0] == '0);
            if (adv) addr_o <= addr_nx;
        end
    end

    // R8
    dir_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flip |=> (addr_o == '0));
    // R6
    dma_single_chk: assert property (@(posedge clk) disable iff (rst)
        dma_o |=> !dma_o);
    // R6
    dma_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        dma_o |-> (addr_o[LO_W-1:0] == '0));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise_i && !fall_i && !flip) |=> $stable(addr_o));
endmodule

// File: rtl/pp_host_addr.sv
module pp_host_addr #(
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    input  logic            clr_i,
    output logic [LO_W-1:0] lo_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) lo_o <= '0;
        else if (adv_i)   lo_o <= lo_o + 1'b1;
    end

    // R7
    host_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (lo_o == '0));
endmodule

// File: rtl/pp_store.sv
module pp_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pp_sample_buf.sv
module pp_sample_buf
    import pp_buf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_tx,
    input  logic              host_stb,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    input  logic              cnv_clk,
    input  logic [DATA_W-1:0] cnv_din,
    output logic [DATA_W-1:0] cnv_dout,
    output logic              dma_req
);
    localparam int LO_W   = $clog2(HALF_DEPTH);
    localparam int ADDR_W = LO_W + 1;

    logic              host_rise, host_fall, cnv_rise, cnv_fall;
    logic              cnv_wr, we;
    logic [LO_W-1:0]   host_lo;
    logic [ADDR_W-1:0] host_addr, cnv_addr, waddr;
    logic [DATA_W-1:0] wdata;
    cv_state_t         mode;

    pp_edge_sync #(.STAGES(SYNC_STAGES)) u_host_sync (
        .clk(clk), .rst(rst), .async_i(host_stb),
        .rise_o(host_rise), .fall_o(host_fall));

    pp_edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
        .clk(clk), .rst(rst), .async_i(cnv_clk),
        .rise_o(cnv_rise), .fall_o(cnv_fall));

    pp_cnv_addr #(.ADDR_W(ADDR_W)) u_cnv_addr (
        .clk(clk), .rst(rst), .dir_tx(dir_tx),
        .rise_i(cnv_rise), .fall_i(cnv_fall),
        .addr_o(cnv_addr), .wr_o(cnv_wr), .dma_o(dma_req), .state_o(mode));

    pp_host_addr #(.LO_W(LO_W)) u_host_addr (
        .clk(clk), .rst(rst), .adv_i(host_fall), .clr_i(dma_req),
        .lo_o(host_lo));

    // host half is always the one the converter is not using
    assign host_addr = {~cnv_addr[ADDR_W-1], host_lo};

    always_comb begin
        unique case (mode)
            CV_TX: begin
                we    = host_fall;
                waddr = host_addr;
                wdata = host_din;
            end
            CV_RX: begin
                we    = cnv_wr;
                waddr = cnv_addr;
                wdata = cnv_din;
            end
        endcase
    end

    pp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .raddr_a_i(host_addr), .raddr_b_i(cnv_addr),
        .rdata_a_o(host_dout), .rdata_b_o(cnv_dout));

    // R4
    write_half_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (mode == CV_TX ? waddr[ADDR_W-1] != cnv_addr[ADDR_W-1]
                              : waddr == cnv_addr));
    // R10
    host_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rise && !dma_req) |=> $stable(host_lo));
endmodule

// File: tb/pp_sample_buf_tb_top.sv
module pp_sample_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_tx = 1'b1;
    logic       host_stb = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       cnv_clk = 1'b0;
    logic [7:0] cnv_din = 8'h00;
    logic [7:0] cnv_dout;
    logic       dma_req;

    always #10 clk = ~clk;

    pp_sample_buf dut_i (
        .clk(clk), .rst(rst), .dir_tx(dir_tx),
        .host_stb(host_stb), .host_din(host_din), .host_dout(host_dout),
        .cnv_clk(cnv_clk), .cnv_din(cnv_din), .cnv_dout(cnv_dout),
        .dma_req(dma_req));

    int   n_tests = 0;
    int   n_fail  = 0;
    int   dma_seen = 0;
    int   dma_exp  = 0;
    bit   done = 1'b0;

    logic [7:0] m_mem [16];
    logic [3:0] m_cnv;
    logic [2:0] m_host;

    always @(negedge clk) if (!rst && dma_req) dma_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [3:0] ha;
        ha = {~m_cnv[3], m_host};
        chk(host_dout == m_mem[ha], req, host_dout, m_mem[ha]);
        chk(cnv_dout == m_mem[m_cnv], req, cnv_dout, m_mem[m_cnv]);
        chk(dma_seen == dma_exp, {req, " dma"}, dma_seen, dma_exp);
    endtask

    task automatic cnv_advance();
        m_cnv = m_cnv + 4'd1;
        if (m_cnv[2:0] == 3'd0) begin
            dma_exp++;
            m_host = 3'd0;
        end
    endtask

    task automatic host_pulse(input logic [7:0] d);
        host_din = d;
        host_stb = 1'b1;
        settle();
        check_all("R10 host rise");
        host_stb = 1'b0;
        settle();
        if (dir_tx) m_mem[{~m_cnv[3], m_host}] = d;
        m_host = m_host + 3'd1;
        check_all(dir_tx ? "R2" : "R10");
    endtask

    task automatic cnv_cycle(input logic [7:0] d);
        cnv_din = d;
        cnv_clk = 1'b1;
        settle();
        if (dir_tx) cnv_advance();
        check_all("R5 rise");
        cnv_clk = 1'b0;
        settle();
        if (!dir_tx) begin
            m_mem[m_cnv] = d;
            cnv_advance();
        end
        check_all(dir_tx ? "R5 fall" : "R3");
    endtask

    task automatic set_dir(input logic v);
        dir_tx = v;
        settle();
        m_cnv = 4'd0;
        check_all("R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
        m_cnv  = 4'd0;
        m_host = 3'd0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1 reset state
        chk(host_dout == 8'h00, "R1", host_dout, 0);
        chk(cnv_dout == 8'h00, "R1", cnv_dout, 0);
        chk(dma_req == 1'b0, "R1", dma_req, 0);

        // transmit sweep: R2, R4, R6, R7, R9, R10
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 8; i++) host_pulse(8'(b * 37 + i * 5 + 3));
            if (b == 2) begin
                // stray strobes, cleared by the next request (R7)
                for (int i = 0; i < 3; i++) host_pulse(8'(200 + i));
            end
            for (int i = 0; i < 8; i++) cnv_cycle(8'(i * 11 + 90));
        end
        // R7: host writes after the request land at word 0
        host_pulse(8'hA5);
        chk(m_host == 3'd1, "R7", m_host, 1);

        // direction flip mid-count (R8)
        for (int i = 0; i < 3; i++) cnv_cycle(8'h33);
        set_dir(1'b0);

        // receive sweep: R3, R5, R6, R9, R10
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 8; i++) cnv_cycle(8'(b * 29 + i * 7 + 1));
            for (int i = 0; i < 8; i++) host_pulse(8'(255 - i));
        end
        for (int i = 0; i < 5; i++) cnv_cycle(8'(i + 150));
        set_dir(1'b1);
        for (int i = 0; i < 8; i++) cnv_cycle(8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule